// File: doc/BRIEF.md
# Program Busy Status Readback

This block produces the byte returned on the read bus of a sector-programmed nonvolatile memory. It covers both idle operation and the time an internal program cycle runs. While the busy input is high, array data is replaced by a polling byte. The polling byte carries two independent completion indicators, so host software can see when programming ends without a separate status register. The first indicator is the most significant bit, returned inverted relative to the most significant bit of the final byte loaded before programming began. The second indicator is the next bit down, which changes value on every new read access. When busy drops, reads return true array data again.

A read access is recognised from three active-low controls: chip select, read enable and write enable. The controls are sampled on the clock, and a new access is counted on the rising edge of the sampled read qualifier. A read held over many clocks therefore counts once. The toggle is cleared when each busy period begins, so the first poll of a period has a known toggle value. Busy may come from a real program cycle or from a dummy cycle started by a rejected protected write. The block treats both the same.

Top module: `busy_readback`

## Requirements
- R1: After reset, rd_oe is 0 and rd_byte is all zeros until a read access is recognised.
- R2: A read is recognised one clock edge after chip_sel_n=0, rd_en_n=0 and wr_en_n=1 are sampled together. In every clock where the previous sample was not that pattern, rd_oe is 0 and rd_byte is 0.
- R3: During a recognised read while busy=1, rd_byte bit 7 (the MSB) equals the inverse of last_msb.
- R4: While busy=1, rd_byte bit 6 (MSB-1) takes the opposite value on each new read access. It stays constant for the whole of one access, however many clocks that access lasts.
- R5: Each busy period starts with the toggle cleared. The first read access of the period returns bit 6 = 1, and the second returns bit 6 = 0.
- R6: During a read while busy=1, bits 5 down to 0 are 0, and arr_byte has no effect on rd_byte.
- R7: During a read while busy=0, rd_byte equals arr_byte on all eight bits. This follows arr_byte as it changes within the access.
- R8: A control pattern that is not a read does not advance the toggle, even when it is held for several clocks during busy (for example write enable low with chip select and read enable low). The next real read shows bit 6 advanced by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | High while an internal program cycle or dummy cycle runs |
| last_msb | input | 1 | MSB of the last byte loaded before programming |
| arr_byte | input | DATA_W | Array read data for the current address |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Read enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_byte | output | DATA_W | Byte for the read bus |
| rd_oe | output | 1 | High while a recognised read drives rd_byte |

## Verification
The bench builds the block with its default DATA_W of 8. That places the inverted indicator on bit 7, the toggle on bit 6 and the forced-zero field on bits 5 to 0, matching the encodings in the requirements. Random access lengths of one to four clocks make it possible to tell a toggle that advances per access from one that advances per clock. Random non-read patterns between accesses, and busy periods that start and stop between reads, make it possible to check that the toggle is cleared and that idle patterns do not advance it.

// File: rtl/poll_pkg.sv
package poll_pkg;

    // Where the read bus takes its byte from
    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_POLL  = 2'd1,
        SRC_ARRAY = 2'd2
    } src_e;

    // Read access events derived from the sampled controls
    typedef struct packed {
        logic active;   // a recognised read is in progress
        logic start;    // first clock of a new read access
    } rd_evt_t;

    // Combinational qualifier: select and read enable low, write enable high
    function automatic logic is_read(input logic sel_n, input logic ren_n,
                                     input logic wen_n);
        return !sel_n && !ren_n && wen_n;
    endfunction

    function automatic src_e pick_src(input logic active, input logic busy);
        if (!active)
            return SRC_OFF;
        return busy ? SRC_POLL : SRC_ARRAY;
    endfunction

endpackage

// File: rtl/bsr_read_detect.sv
module bsr_read_detect
    import poll_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    chip_sel_n,
    input  logic    rd_en_n,
    input  logic    wr_en_n,
    output rd_evt_t evt
);

    logic qual_now;
    logic qual_q;

    assign qual_now = is_read(chip_sel_n, rd_en_n, wr_en_n);

    always_ff @(posedge clk) begin
        if (rst)
            qual_q <= 1'b0;
        else
            qual_q <= qual_now;
    end

    always_comb begin
        evt.active = qual_q;
        evt.start  = qual_now && !qual_q;
    end

endmodule

// File: rtl/bsr_toggle.sv
module bsr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic start,
    output logic tog
);

    logic busy_q;
    logic busy_rise;

    assign busy_rise = busy && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tog    <= 1'b0;
        end else begin
            busy_q <= busy;
            if (busy_rise)
                tog <= start;       // cleared, or counts a read that opens the period
            else if (busy && start)
                tog <= ~tog;
        end
    end

    // R5
    first_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_rise && !start) |=> !tog);

endmodule

// File: rtl/bsr_out_mux.sv
module bsr_out_mux
    import poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  src_e              src,
    input  logic              last_msb,
    input  logic              tog,
    input  logic [DATA_W-1:0] arr_byte,
    output logic [DATA_W-1:0] out_byte
);

    localparam int LOW_W = DATA_W - 2;

    always_comb begin
        case (src)
            SRC_POLL:  out_byte = {~last_msb, tog, {LOW_W{1'b0}}};
            SRC_ARRAY: out_byte = arr_byte;
            default:   out_byte = '0;
        endcase
    end

endmodule

// File: rtl/busy_readback.sv
module busy_readback
    import poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              last_msb,
    input  logic [DATA_W-1:0] arr_byte,
    input  logic              chip_sel_n,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_oe
);

    localparam int MSB     = DATA_W - 1;
    localparam int TOG_BIT = DATA_W - 2;
    localparam int LOW_W   = DATA_W - 2;

    rd_evt_t evt;
    logic    tog;
    src_e    src;

    bsr_read_detect u_detect (
        .clk        (clk),
        .rst        (rst),
        .chip_sel_n (chip_sel_n),
        .rd_en_n    (rd_en_n),
        .wr_en_n    (wr_en_n),
        .evt        (evt)
    );

    bsr_toggle u_toggle (
        .clk   (clk),
        .rst   (rst),
        .busy  (busy),
        .start (evt.start),
        .tog   (tog)
    );

    assign src = pick_src(evt.active, busy);

    bsr_out_mux #(.DATA_W(DATA_W)) u_mux (
        .src      (src),
        .last_msb (last_msb),
        .tog      (tog),
        .arr_byte (arr_byte),
        .out_byte (rd_byte)
    );

    assign rd_oe = evt.active;

    // R2
    read_qual_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> $past(!chip_sel_n && !rd_en_n && wr_en_n));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_oe |-> (rd_byte == '0));

    // R3
    poll_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_oe && busy) |-> (rd_byte[MSB] == !last_msb));

    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_oe && busy && $past(rd_oe) && $past(busy)) |-> $stable(rd_byte[TOG_BIT]));

    // R6
    poll_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_oe && busy) |-> (rd_byte[LOW_W-1:0] == '0));

    // R7
    true_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_oe && !busy) |-> (rd_byte == arr_byte));

endmodule

// File: tb/sim_busy_readback.sv
module sim_busy_readback;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          busy = 1'b0;
    logic          last_msb = 1'b0;
    logic [DW-1:0] arr_byte = '0;
    logic          chip_sel_n = 1'b1;
    logic          rd_en_n = 1'b1;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] rd_byte;
    logic          rd_oe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic tog_m = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    busy_readback #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .busy(busy), .last_msb(last_msb),
        .arr_byte(arr_byte), .chip_sel_n(chip_sel_n), .rd_en_n(rd_en_n),
        .wr_en_n(wr_en_n), .rd_byte(rd_byte), .rd_oe(rd_oe)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, got %0d cycles expected below 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [DW-1:0] exp_poll(input logic msb, input logic t);
        return {~msb, t, 6'b0};
    endfunction

    task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_byte;
        if (busy) begin
            chk({7'b0, rd_byte[7]}, {7'b0, ~last_msb}, "R3 inverted msb");
            chk({7'b0, rd_byte[6]}, {7'b0, tog_m}, "R4 toggle bit");
            chk({2'b0, rd_byte[5:0]}, 8'h00, "R6 low bits zero");
        end else begin
            chk(rd_byte, arr_byte, "R7 true data");
        end
        chk({7'b0, rd_oe}, 8'h01, "R2 read recognised");
    endtask

    // One read access lasting len clocks; starts and ends on a negedge
    task automatic do_read(input int len);
        chip_sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b1;
        if (busy) tog_m = ~tog_m;
        for (int k = 0; k < len; k++) begin
            arr_byte = DW'($urandom);
            @(posedge clk); @(negedge clk);
            chk_byte();
        end
        chip_sel_n = 1'b1; rd_en_n = 1'b1;
    endtask

    // Non-read control patterns held for n clocks
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            case ($urandom % 4)
                0: begin chip_sel_n = 1'b1; rd_en_n = 1'b0; wr_en_n = 1'b1; end
                1: begin chip_sel_n = 1'b0; rd_en_n = 1'b1; wr_en_n = 1'b1; end
                2: begin chip_sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b0; end
                default: begin chip_sel_n = 1'b1; rd_en_n = 1'b1; wr_en_n = 1'b1; end
            endcase
            arr_byte = DW'($urandom);
            @(posedge clk); @(negedge clk);
            chk({7'b0, rd_oe}, 8'h00, "R2 no read output enable");
            chk(rd_byte, 8'h00, "R2 idle byte zero");
        end
        chip_sel_n = 1'b1; rd_en_n = 1'b1; wr_en_n = 1'b1;
    endtask

    task automatic set_busy(input logic b);
        if (b && !busy) tog_m = 1'b0;
        busy = b;
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        // R1 reset state
        chk({7'b0, rd_oe}, 8'h00, "R1 reset output enable");
        chk(rd_byte, 8'h00, "R1 reset byte");

        // R7 idle reads, R2 rejected patterns
        do_read(2);
        idle(1);
        chip_sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({7'b0, rd_oe}, 8'h00, "R2 write enable low blocks read");
        idle(1);

        // R5 first read of busy period returns toggle 1, then 0
        last_msb = 1'b1;
        set_busy(1'b1);
        idle(2);
        do_read(1);
        chk({7'b0, rd_byte[6]}, 8'h01, "R5 first poll toggle one");
        idle(1);
        do_read(5);  // R4 long read keeps bit steady
        chk({7'b0, rd_byte[6]}, 8'h00, "R5 second poll toggle zero");
        // R8 non-read patterns do not advance the toggle
        idle(6);
        do_read(1);
        chk({7'b0, rd_byte[6]}, 8'h01, "R8 toggle advanced once");
        last_msb = 1'b0;
        idle(1);
        do_read(2);
        set_busy(1'b0);
        idle(1);
        do_read(3);  // R7 true data after busy ends
        // R5 new busy period clears toggle again
        set_busy(1'b1);
        idle(1);
        do_read(1);
        chk({7'b0, rd_byte[6]}, 8'h01, "R5 cleared on new busy period");
        idle(1);

        // Random mixture
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 6) == 0) set_busy(~busy);
            last_msb = 1'($urandom);
            idle(1 + ($urandom % 3));
            do_read(1 + ($urandom % 4));
        end
        idle(1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule